// File: doc/BRIEF.md
# Accumulator ALU Flag Generator

This block builds the eight-bit condition register that sits beside an 8-bit accumulator ALU and its 16-bit add path. For each operation it forms the arithmetic or logic result, then works out sign, zero, half-carry, parity/overflow, subtract and carry. It also tracks the two bits at positions 5 and 3 that are often tied off. Here they are stored and they follow the result. The register can be written whole in one cycle and read whole at the output, so a push/pop of the accumulator-and-flags pair keeps every bit.

Each operation offers its result on `result_o` in the same cycle. When `upd_i` is high, the new flags are taken at the next rising clock edge. A whole-register write has priority over an update. Operations that do not touch flags, and unused operation codes, leave all eight bits as they were. Flag layout: bit 7 sign (S), 6 zero (Z), 5 Y, 4 half-carry (H), 3 X, 2 parity/overflow (PV), 1 subtract (N), 0 carry (C).

Top module: `alu_flag_unit`

## Requirements
- R1: After reset `flags_o` is 8'h00.
- R2: When `flag_we_i` is high, `flags_o` equals `flag_wdata_i` after the next edge, all eight bits included, even if `upd_i` is also high.
- R3: When `upd_i` is low, or `op_i` is an unused code (11 to 15), `flags_o` stays as it was, bits 5 and 3 included.
- R4: For 8-bit operations, S, Y and X take bits 7, 5 and 3 of the 8-bit result, and Z is set when that result is zero. The exceptions are listed in R7 and R11.
- R5: ADD (op 0) and ADC (op 1, which adds C) set C to the carry out of bit 7 and H to the carry out of bit 3. PV is set on signed overflow and N is cleared.
- R6: SUB (op 2) and SBC (op 3, which subtracts C) set C on borrow out of bit 7 and H on borrow out of bit 3. PV is set on signed overflow and N is set.
- R7: Compare (op 4) sets its flags as SUB does, except that Y and X take bits 5 and 3 of the operand `b_i`.
- R8: AND (op 5) sets H. OR (op 6) and XOR (op 7) clear H. All three clear N and C and set PV to even parity of the result.
- R9: Bit test (op 8) of bit `bit_sel_i` of `b_i` forms the result `b_i & (1<<bit_sel_i)`. S, Y and X follow that result, so S is set only when bit 7 is tested and is one. Z and PV are set when the tested bit is zero, H is set, N is cleared and C is kept.
- R10: 16-bit add (op 9) of `wa_i + wb_i` takes S, Y and X from result bits 15, 13 and 11. Z is set when all 16 bits are zero and H is the carry out of bit 11. C is the carry out of bit 15, PV is signed 16-bit overflow and N is cleared.
- R11: Load of the vector/refresh value (op 10, value on `b_i`) sets S, Z, Y and X from that value, copies `iff2_i` into PV, clears H and N, and keeps C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | 8-bit accumulator operand |
| b_i | input | 8 | 8-bit second operand, test value or loaded value |
| wa_i | input | 16 | 16-bit first operand |
| wb_i | input | 16 | 16-bit second operand |
| bit_sel_i | input | 3 | Bit index for bit test |
| iff2_i | input | 1 | Second interrupt-enable state for op 10 |
| upd_i | input | 1 | Flag update enable |
| flag_we_i | input | 1 | Whole-register write strobe |
| flag_wdata_i | input | 8 | Whole-register write data |
| flags_o | output | 8 | Flag register |
| result_o | output | 16 | Operation result (8-bit results zero-extended) |

## Verification
On every cycle, the assertions check that flags are held when nothing writes them and that a whole write restores its value exactly. They also check that S, Y and X track the offered result, and that compare takes Y and X from its operand. Further cycle-by-cycle checks cover the sign-from-bit-15 rule for the 16-bit add, the bit-7 test case and the copy of `iff2_i` into PV. Carry, half-carry and overflow values at operand boundaries, the parity results and the preservation of C are shown only by the bench's vectors.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int DW   = 8;
  localparam int WW   = 2 * DW;
  localparam int OPW  = 4;
  localparam int SELW = $clog2(DW);

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 4'd0,
    OP_ADC   = 4'd1,
    OP_SUB   = 4'd2,
    OP_SBC   = 4'd3,
    OP_CMP   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_BIT   = 4'd8,
    OP_ADDW  = 4'd9,
    OP_LDSPC = 4'd10
  } alu_op_e;

  // flag bit positions
  localparam int F_C  = 0;
  localparam int F_N  = 1;
  localparam int F_PV = 2;
  localparam int F_X  = 3;
  localparam int F_H  = 4;
  localparam int F_Y  = 5;
  localparam int F_Z  = 6;
  localparam int F_S  = 7;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         half_o,
  output logic         ovf_o
);
  localparam int LW = W - 4;

  logic [W:0]  full;
  logic [LW:0] low;

  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      low  = {1'b0, a_i[LW-1:0]} - {1'b0, b_i[LW-1:0]} - {{LW{1'b0}}, cin_i};
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      low  = {1'b0, a_i[LW-1:0]} + {1'b0, b_i[LW-1:0]} + {{LW{1'b0}}, cin_i};
    end
  end

  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
  assign half_o  = low[LW];
  // signed overflow: operand signs agree (add) or differ (sub), result sign flips
  assign ovf_o   = ((a_i[W-1] ^ b_i[W-1]) == sub_i) && (full[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_result_path.sv
module alu_result_path
  import alu_flag_pkg::*;
(
  input  logic [OPW-1:0]  op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [WW-1:0]   wa_i,
  input  logic [WW-1:0]   wb_i,
  input  logic [SELW-1:0] bit_sel_i,
  input  logic            carry_i,
  output logic [WW-1:0]   res_o,
  output logic            c8_o,
  output logic            h8_o,
  output logic            v8_o,
  output logic            c16_o,
  output logic            h16_o,
  output logic            v16_o
);
  logic          is_sub;
  logic          cin8;
  logic [DW-1:0] sum8;
  logic [WW-1:0] sum16;
  logic [DW-1:0] mask;

  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CMP);
  assign cin8   = ((op_i == OP_ADC) || (op_i == OP_SBC)) && carry_i;

  alu_addsub #(.W(DW)) u_add8 (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin8),
    .sub_i   (is_sub),
    .sum_o   (sum8),
    .carry_o (c8_o),
    .half_o  (h8_o),
    .ovf_o   (v8_o)
  );

  alu_addsub #(.W(WW)) u_add16 (
    .a_i     (wa_i),
    .b_i     (wb_i),
    .cin_i   (1'b0),
    .sub_i   (1'b0),
    .sum_o   (sum16),
    .carry_o (c16_o),
    .half_o  (h16_o),
    .ovf_o   (v16_o)
  );

  generate
    for (genvar g = 0; g < DW; g++) begin : g_mask
      assign mask[g] = (bit_sel_i == SELW'(g));
    end
  endgenerate

  always_comb begin
    res_o = '0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: res_o[DW-1:0] = sum8;
      OP_AND:   res_o[DW-1:0] = a_i & b_i;
      OP_OR:    res_o[DW-1:0] = a_i | b_i;
      OP_XOR:   res_o[DW-1:0] = a_i ^ b_i;
      OP_BIT:   res_o[DW-1:0] = b_i & mask;
      OP_ADDW:  res_o         = sum16;
      OP_LDSPC: res_o[DW-1:0] = b_i;
      default:  res_o         = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_calc.sv
module alu_flag_calc
  import alu_flag_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [WW-1:0]  res_i,
  input  logic [DW-1:0]  b_i,
  input  logic           iff2_i,
  input  logic [DW-1:0]  cur_i,
  input  logic           c8_i,
  input  logic           h8_i,
  input  logic           v8_i,
  input  logic           c16_i,
  input  logic           h16_i,
  input  logic           v16_i,
  output logic [DW-1:0]  nxt_o,
  output logic           hit_o
);
  logic [DW-1:0] r8;
  logic [DW-1:0] hi;
  logic          z8;

  assign r8 = res_i[DW-1:0];
  assign hi = res_i[WW-1:DW];
  assign z8 = (r8 == '0);

  function automatic logic [DW-1:0] pack(logic s, logic z, logic y, logic h,
                                         logic x, logic pv, logic n, logic c);
    logic [DW-1:0] f;
    f       = '0;
    f[F_S]  = s;
    f[F_Z]  = z;
    f[F_Y]  = y;
    f[F_H]  = h;
    f[F_X]  = x;
    f[F_PV] = pv;
    f[F_N]  = n;
    f[F_C]  = c;
    return f;
  endfunction

  always_comb begin
    nxt_o = cur_i;
    hit_o = 1'b1;
    case (op_i)
      OP_ADD, OP_ADC:
        nxt_o = pack(r8[DW-1], z8, r8[5], h8_i, r8[3], v8_i, 1'b0, c8_i);
      OP_SUB, OP_SBC:
        nxt_o = pack(r8[DW-1], z8, r8[5], h8_i, r8[3], v8_i, 1'b1, c8_i);
      // compare: Y/X from the operand, not the difference
      OP_CMP:
        nxt_o = pack(r8[DW-1], z8, b_i[5], h8_i, b_i[3], v8_i, 1'b1, c8_i);
      OP_AND:
        nxt_o = pack(r8[DW-1], z8, r8[5], 1'b1, r8[3], ~^r8, 1'b0, 1'b0);
      OP_OR, OP_XOR:
        nxt_o = pack(r8[DW-1], z8, r8[5], 1'b0, r8[3], ~^r8, 1'b0, 1'b0);
      OP_BIT:
        nxt_o = pack(r8[DW-1], z8, r8[5], 1'b1, r8[3], z8, 1'b0, cur_i[F_C]);
      // 16-bit: upper byte supplies S/Y/X
      OP_ADDW:
        nxt_o = pack(hi[DW-1], res_i == '0, hi[5], h16_i, hi[3], v16_i, 1'b0, c16_i);
      OP_LDSPC:
        nxt_o = pack(r8[DW-1], z8, r8[5], 1'b0, r8[3], iff2_i, 1'b0, cur_i[F_C]);
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OPW-1:0]  op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [WW-1:0]   wa_i,
  input  logic [WW-1:0]   wb_i,
  input  logic [SELW-1:0] bit_sel_i,
  input  logic            iff2_i,
  input  logic            upd_i,
  input  logic            flag_we_i,
  input  logic [DW-1:0]   flag_wdata_i,
  output logic [DW-1:0]   flags_o,
  output logic [WW-1:0]   result_o
);
  logic [DW-1:0] flags_q;
  logic [DW-1:0] flags_d;
  logic          hit;
  logic          c8, h8, v8, c16, h16, v16;

  alu_result_path u_path (
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .wa_i      (wa_i),
    .wb_i      (wb_i),
    .bit_sel_i (bit_sel_i),
    .carry_i   (flags_q[F_C]),
    .res_o     (result_o),
    .c8_o      (c8),
    .h8_o      (h8),
    .v8_o      (v8),
    .c16_o     (c16),
    .h16_o     (h16),
    .v16_o     (v16)
  );

  alu_flag_calc u_calc (
    .op_i   (op_i),
    .res_i  (result_o),
    .b_i    (b_i),
    .iff2_i (iff2_i),
    .cur_i  (flags_q),
    .c8_i   (c8),
    .h8_i   (h8),
    .v8_i   (v8),
    .c16_i  (c16),
    .h16_i  (h16),
    .v16_i  (v16),
    .nxt_o  (flags_d),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flags_q <= '0;
    else if (flag_we_i) flags_q <= flag_wdata_i;
    else if (upd_i && hit) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  logic upd8;
  assign upd8 = upd_i && !flag_we_i &&
                (op_i inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_OR,
                              OP_XOR, OP_BIT, OP_LDSPC});

  p_restore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o == $past(flag_wdata_i));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_we_i && !upd_i) |=> $stable(flags_o));

  p_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd8 |=> (flags_o[F_S] == $past(result_o[7])) &&
             (flags_o[F_Y] == $past(result_o[5])) &&
             (flags_o[F_X] == $past(result_o[3])));

  p_cmp_yx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !flag_we_i && op_i == OP_CMP) |=>
      (flags_o[F_Y] == $past(b_i[5])) && (flags_o[F_X] == $past(b_i[3])) && flags_o[F_N]);

  p_bit7_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !flag_we_i && op_i == OP_BIT && bit_sel_i == 3'd7 && b_i[7]) |=> flags_o[F_S]);

  p_sign16_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !flag_we_i && op_i == OP_ADDW) |=>
      (flags_o[F_S] == $past(result_o[15])) && (flags_o[F_Y] == $past(result_o[13])));

  p_iff2_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !flag_we_i && op_i == OP_LDSPC) |=> flags_o[F_PV] == $past(iff2_i));
endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  // {op, a, b, bit_sel, iff2, preset flags, expected flags}
  localparam logic [39:0] VEC [NV] = '{
    {4'd0,  8'h0F, 8'h01, 3'd0, 1'b0, 8'h00, 8'h10}, // R5 half carry
    {4'd0,  8'h7F, 8'h01, 3'd0, 1'b0, 8'h00, 8'h94}, // R5 overflow
    {4'd0,  8'hFF, 8'h01, 3'd0, 1'b0, 8'h00, 8'h51}, // R5/R4 carry, zero
    {4'd0,  8'h20, 8'h08, 3'd0, 1'b0, 8'h00, 8'h28}, // R4 Y/X
    {4'd1,  8'h10, 8'h17, 3'd0, 1'b0, 8'h01, 8'h28}, // R5 adc
    {4'd2,  8'h10, 8'h01, 3'd0, 1'b0, 8'h00, 8'h1A}, // R6 half borrow
    {4'd2,  8'h00, 8'h01, 3'd0, 1'b0, 8'h00, 8'hBB}, // R6 borrow
    {4'd2,  8'h80, 8'h01, 3'd0, 1'b0, 8'h00, 8'h3E}, // R6 overflow
    {4'd3,  8'h05, 8'h05, 3'd0, 1'b0, 8'h01, 8'hBB}, // R6 sbc
    {4'd4,  8'h40, 8'h28, 3'd0, 1'b0, 8'h00, 8'h3A}, // R7 Y/X from b
    {4'd4,  8'h05, 8'h05, 3'd0, 1'b0, 8'h00, 8'h42}, // R7 equal
    {4'd5,  8'hF0, 8'h3C, 3'd0, 1'b0, 8'hFF, 8'h34}, // R8 and
    {4'd6,  8'h01, 8'h02, 3'd0, 1'b0, 8'hFF, 8'h04}, // R8 or
    {4'd7,  8'hFF, 8'h7F, 3'd0, 1'b0, 8'hFF, 8'h80}, // R8 xor odd
    {4'd7,  8'h55, 8'h55, 3'd0, 1'b0, 8'hFF, 8'h44}, // R8 xor zero
    {4'd8,  8'h00, 8'h80, 3'd7, 1'b0, 8'h01, 8'h91}, // R9 bit7 set
    {4'd8,  8'h00, 8'h7F, 3'd7, 1'b0, 8'h00, 8'h54}, // R9 bit7 clear
    {4'd8,  8'h00, 8'h20, 3'd5, 1'b0, 8'h00, 8'h30}, // R9 bit5
    {4'd8,  8'h00, 8'h08, 3'd3, 1'b0, 8'h01, 8'h19}, // R9 bit3 keeps C
    {4'd10, 8'h00, 8'h00, 3'd0, 1'b1, 8'h01, 8'h45}, // R11 iff2 set
    {4'd10, 8'h00, 8'hA8, 3'd0, 1'b0, 8'h00, 8'hA8}  // R11 iff2 clear
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [7:0]  a_i = '0, b_i = '0, flag_wdata_i = '0;
  logic [15:0] wa_i = '0, wb_i = '0;
  logic [2:0]  bit_sel_i = '0;
  logic        iff2_i = 1'b0, upd_i = 1'b0, flag_we_i = 1'b0;
  logic [7:0]  flags_o;
  logic [15:0] result_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alu_flag_unit u_dut (
    .clk_i, .rst_ni, .op_i, .a_i, .b_i, .wa_i, .wb_i, .bit_sel_i, .iff2_i,
    .upd_i, .flag_we_i, .flag_wdata_i, .flags_o, .result_o
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic preset(logic [7:0] v);
    @(negedge clk_i);
    flag_we_i = 1'b1; flag_wdata_i = v;
    @(negedge clk_i);
    flag_we_i = 1'b0;
  endtask

  // preset flags, apply one op with update, leave operands held
  task automatic run(logic [7:0] pre, logic [3:0] op, logic [7:0] a, logic [7:0] b,
                     logic [15:0] wa, logic [15:0] wb, logic [2:0] sel, logic iff2);
    preset(pre);
    op_i = op; a_i = a; b_i = b; wa_i = wa; wb_i = wb; bit_sel_i = sel; iff2_i = iff2;
    upd_i = 1'b1;
    @(negedge clk_i);
    upd_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 reset", {8'h0, flags_o}, 16'h0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][15:8], VEC[i][39:36], VEC[i][35:28], VEC[i][27:20],
          16'h0, 16'h0, VEC[i][19:17], VEC[i][16]);
      check($sformatf("R4-vec%0d", i), {8'h0, flags_o}, {8'h0, VEC[i][7:0]});
    end

    // R2: whole write keeps bits 5 and 3
    preset(8'h28);
    check("R2 restore", {8'h0, flags_o}, 16'h0028);
    preset(8'hD7);
    check("R2 restore", {8'h0, flags_o}, 16'h00D7);
    // R2: write wins over a simultaneous update
    @(negedge clk_i);
    op_i = 4'd0; a_i = 8'hFF; b_i = 8'h01; upd_i = 1'b1;
    flag_we_i = 1'b1; flag_wdata_i = 8'h2A;
    @(negedge clk_i);
    flag_we_i = 1'b0; upd_i = 1'b0;
    check("R2 priority", {8'h0, flags_o}, 16'h002A);

    // R3: no update enable
    @(negedge clk_i);
    op_i = 4'd0; a_i = 8'h7F; b_i = 8'h01;
    repeat (2) @(negedge clk_i);
    check("R3 hold", {8'h0, flags_o}, 16'h002A);
    // R3: unused code with update enable
    run(8'h28, 4'd12, 8'hFF, 8'hFF, 16'h0, 16'h0, 3'd0, 1'b0);
    check("R3 unused op", {8'h0, flags_o}, 16'h0028);

    // R10: 16-bit add
    run(8'h00, 4'd9, 8'h0, 8'h0, 16'h0FFF, 16'h0001, 3'd0, 1'b0);
    check("R10 half", {8'h0, flags_o}, 16'h0010);
    check("R10 result", result_o, 16'h1000);
    run(8'h00, 4'd9, 8'h0, 8'h0, 16'hFFFF, 16'h0001, 3'd0, 1'b0);
    check("R10 zero carry", {8'h0, flags_o}, 16'h0051);
    run(8'h00, 4'd9, 8'h0, 8'h0, 16'h7FFF, 16'h0001, 3'd0, 1'b0);
    check("R10 sign overflow", {8'h0, flags_o}, 16'h0094);
    run(8'hFF, 4'd9, 8'h0, 8'h0, 16'h2800, 16'h0000, 3'd0, 1'b0);
    check("R10 upper Y/X", {8'h0, flags_o}, 16'h0028);

    // R4: zero result of 8-bit op ignores 16-bit operands
    run(8'h00, 4'd0, 8'h80, 8'h80, 16'hFFFF, 16'hFFFF, 3'd0, 1'b0);
    check("R4 zero", {8'h0, flags_o}, 16'h0045);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule